// File: doc/BRIEF.md
# SPI Memory-Access Transaction Engine

This block is an SPI bus master that reaches the memory space of an external graphics controller. A client places one request at a time on a simple request port: an operation (read, write or command), a 22-bit target address, a payload byte count and, for commands, an 8-bit command code. The engine frames the request, shifts it out MSB first in SPI mode 0 and runs chip select around the whole frame. Write payload bytes are pulled from the client one at a time with a ready/valid handshake. Read payload bytes are returned with a one-cycle valid strobe.

Every frame opens with three header bytes. For reads and writes, the two top bits of the first byte give the direction, and its low six bits hold address bits 21..16. A read clocks one extra don't-care byte after the header before real data arrives. A command is always a fixed three-byte frame. Requests whose payload would overflow the device's 16-bit transfer length are refused with an error pulse.

A separate path synchronises the controller's active-high interrupt line and marks each rising edge with a single-cycle pulse.

Top module: `spi_mem_host`

## Requirements
- R1: A write (`req_op`=2'b01) sends the bytes {2'b10, addr[21:16]}, addr[15:8], addr[7:0], followed by exactly `req_len` payload bytes in the order they were handed over. Each byte goes out MSB first.
- R2: A read (`req_op`=2'b00) sends {2'b00, addr[21:16]}, addr[15:8] and addr[7:0], then 1 + `req_len` zero bytes. The first MISO byte after the header is discarded. The next `req_len` MISO bytes appear in order on `rd_data`, each with a one-cycle `rd_valid` pulse.
- R3: A command (`req_op`=2'b10) sends `req_cmd` unchanged, followed by two 0x00 bytes, for any code including 0x00. `req_len` and `req_addr` have no effect on a command.
- R4: The following requests produce a one-cycle `req_err` pulse and start no frame, and `busy` stays low: a write with `req_len` > 2^LEN_W-4, a read with `req_len` > 2^LEN_W-5, or `req_op`=2'b11. A write of exactly 2^LEN_W-4 bytes and a read of exactly 2^LEN_W-5 bytes are accepted.
- R5: The bus uses SPI mode 0. SCLK idles low, and each high and low phase lasts HALF clock cycles. MOSI changes only while SCLK falls or is low, and never at a rising edge. MISO is sampled on the rising edge.
- R6: `spi_cs_n` falls exactly HALF cycles before the first SCLK rise and stays low for the whole frame. It rises together with the final SCLK fall. SCLK is low whenever `spi_cs_n` is high, and `spi_cs_n` stays high for at least GAP cycles between frames.
- R7: `busy` rises in the cycle after a request is accepted and covers the entire frame. It falls GAP cycles after `spi_cs_n` rises. `req_valid` is ignored while `busy` is high.
- R8: Before each write payload byte, `wr_ready` is high and SCLK is held low until `wr_valid` is seen. The byte on `wr_data` is taken on that clock edge.
- R9: A rising edge on `irq_in` gives exactly one `irq_pulse` cycle, three clock edges later. A held level or a falling edge gives no pulse.
- R10: After reset, `spi_cs_n`=1, `spi_sclk`=0, and `busy`, `req_err`, `rd_valid`, `wr_ready` and `irq_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while not busy |
| req_op | input | 2 | 00 read, 01 write, 10 command, 11 invalid |
| req_addr | input | 22 | Target memory address |
| req_len | input | LEN_W (16) | Payload byte count |
| req_cmd | input | 8 | Command code for command requests |
| busy | output | 1 | Transaction in progress, including the CS gap |
| req_err | output | 1 | One-cycle pulse when a request is refused |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte present |
| wr_ready | output | 1 | Engine waiting for the next payload byte |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| irq_in | input | 1 | Asynchronous interrupt line, active high |
| irq_pulse | output | 1 | One-cycle pulse per interrupt rising edge |

## Verification
The embedded properties rely on three things about the environment. The client raises `wr_valid` only when it has a byte. MISO changes only while SCLK is low. Requests are offered as single-cycle strobes, so a refused request cannot be mistaken for one raised during a frame. The bench keeps within these limits: it drives every request and payload input on the falling system-clock edge, and its device model changes MISO only on SCLK falling edges or when chip select falls. It deliberately offers requests while busy, over-length requests and the invalid opcode, so the refusal and ignore paths run under the same assumptions.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int ADDR_W = 22;
  localparam int HDR_BYTES = 3;

  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_CMD = 2'b10,
    OP_BAD = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOW,
    S_HIGH,
    S_FETCH,
    S_GAP
  } st_e;

endpackage

// File: rtl/spi_mem_halfclk.sv
module spi_mem_halfclk #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

endmodule

// File: rtl/spi_mem_irq_edge.sv
module spi_mem_irq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  output logic pulse
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      pulse <= 1'b0;
    end else begin
      sh    <= {sh[STAGES-1:0], irq_in};
      pulse <= sh[STAGES-1] & ~sh[STAGES];
    end
  end

  // R9: each detected edge lasts exactly one cycle
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

endmodule

// File: rtl/spi_mem_host.sv
module spi_mem_host
  import spi_mem_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int HALF  = 4,
  parameter int GAP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        req_cmd,
  output logic              busy,
  output logic              req_err,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  input  logic              irq_in,
  output logic              irq_pulse
);
  localparam int CNT_W  = LEN_W + 1;
  localparam int WR_MAX = (1 << LEN_W) - 1 - HDR_BYTES;
  localparam int RD_MAX = WR_MAX - 1;
  localparam int GW     = $clog2(GAP + 1);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(HDR_BYTES + 1);

  st_e              state;
  op_e              op_q;
  logic [7:0]       hdr1, hdr2, tx_q, rx_q;
  logic [2:0]       bit_q;
  logic [CNT_W-1:0] idx, last_idx;
  logic [GW-1:0]    gap_cnt;
  logic             tick;

  // next byte selection at a byte boundary
  logic [CNT_W-1:0] k_nxt;
  logic [7:0]       nxt_byte;
  logic             need_fetch;
  logic             req_bad;
  logic [7:0]       first_byte;
  op_e              req_op_e;

  assign req_op_e = op_e'(req_op);

  always_comb begin
    k_nxt      = idx + 1'b1;
    nxt_byte   = (k_nxt == CNT_W'(1)) ? hdr1 :
                 (k_nxt == CNT_W'(2)) ? hdr2 : 8'h00;
    need_fetch = (op_q == OP_WR) && (k_nxt >= CNT_W'(HDR_BYTES));
    req_bad    = (req_op_e == OP_BAD) ||
                 ((req_op_e == OP_WR) && (int'(req_len) > WR_MAX)) ||
                 ((req_op_e == OP_RD) && (int'(req_len) > RD_MAX));
    case (req_op_e)
      OP_WR:   first_byte = {2'b10, req_addr[21:16]};
      OP_CMD:  first_byte = req_cmd;
      default: first_byte = {2'b00, req_addr[21:16]};
    endcase
  end

  spi_mem_halfclk #(.HALF(HALF)) u_half (
    .clk  (clk),
    .rst  (rst),
    .run  ((state == S_LOW) || (state == S_HIGH)),
    .tick (tick)
  );

  spi_mem_irq_edge #(.STAGES(2)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .pulse  (irq_pulse)
  );

  assign wr_ready = (state == S_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= OP_RD;
      hdr1     <= '0;
      hdr2     <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      bit_q    <= '0;
      idx      <= '0;
      last_idx <= '0;
      gap_cnt  <= '0;
      busy     <= 1'b0;
      req_err  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      spi_sclk <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_mosi <= 1'b0;
    end else begin
      req_err  <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (req_bad) begin
              req_err <= 1'b1;
            end else begin
              op_q     <= req_op_e;
              hdr1     <= (req_op_e == OP_CMD) ? 8'h00 : req_addr[15:8];
              hdr2     <= (req_op_e == OP_CMD) ? 8'h00 : req_addr[7:0];
              last_idx <= (req_op_e == OP_CMD) ? CNT_W'(HDR_BYTES - 1) :
                          (req_op_e == OP_RD)  ? CNT_W'(req_len) + CNT_W'(HDR_BYTES) :
                                                 CNT_W'(req_len) + CNT_W'(HDR_BYTES - 1);
              idx      <= '0;
              bit_q    <= 3'd7;
              tx_q     <= first_byte;
              spi_mosi <= first_byte[7];
              spi_cs_n <= 1'b0;
              busy     <= 1'b1;
              state    <= S_LOW;
            end
          end
        end
        S_LOW: begin
          if (tick) begin
            spi_sclk <= 1'b1;
            rx_q     <= {rx_q[6:0], spi_miso};
            state    <= S_HIGH;
          end
        end
        S_HIGH: begin
          if (tick) begin
            spi_sclk <= 1'b0;
            if (bit_q != 3'd0) begin
              bit_q    <= bit_q - 1'b1;
              tx_q     <= {tx_q[6:0], 1'b0};
              spi_mosi <= tx_q[6];
              state    <= S_LOW;
            end else begin
              if (op_q == OP_RD && idx >= FIRST_DATA) begin
                rd_data  <= rx_q;
                rd_valid <= 1'b1;
              end
              if (idx == last_idx) begin
                spi_cs_n <= 1'b1;
                spi_mosi <= 1'b0;
                gap_cnt  <= '0;
                state    <= S_GAP;
              end else begin
                idx   <= k_nxt;
                bit_q <= 3'd7;
                if (need_fetch) begin
                  spi_mosi <= 1'b0;
                  state    <= S_FETCH;
                end else begin
                  tx_q     <= nxt_byte;
                  spi_mosi <= nxt_byte[7];
                  state    <= S_LOW;
                end
              end
            end
          end
        end
        S_FETCH: begin
          if (wr_valid) begin
            tx_q     <= wr_data;
            spi_mosi <= wr_data[7];
            state    <= S_LOW;
          end
        end
        S_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GW'(GAP - 1)) begin
            busy  <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: clock idles low outside a frame
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R7: busy covers every cycle of an active frame
  p_busy_frame_r7: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy);

  // R4: a refused request leaves the bus and busy untouched
  p_reject_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!busy && spi_cs_n));

  // R8: while waiting for payload the clock is parked low inside the frame
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> (!spi_sclk && !spi_cs_n));

  // R5: data is never changed at a rising clock edge
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  // R2: read strobes only come from read frames
  p_rdv_read_only_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (op_q == OP_RD));

endmodule

// File: tb/spi_mem_host_test.sv
module spi_mem_host_test;
  localparam int LEN_W  = 8;
  localparam int HALF   = 2;
  localparam int GAP    = 3;
  localparam int WR_MAX = (1 << LEN_W) - 4;
  localparam int RD_MAX = (1 << LEN_W) - 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [21:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0]  req_cmd = '0;
  logic        busy, req_err;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic        irq_in = 1'b0;
  logic        irq_pulse;

  always #10 clk = ~clk;

  spi_mem_host #(.LEN_W(LEN_W), .HALF(HALF), .GAP(GAP)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_cmd(req_cmd),
    .busy(busy), .req_err(req_err), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .irq_in(irq_in), .irq_pulse(irq_pulse)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int j);
    int t;
    t = j * 37 + 11;
    return t[7:0];
  endfunction

  function automatic logic pat_bit(input int f);
    logic [7:0] b;
    b = pat(f / 8);
    return b[7 - (f % 8)];
  endfunction

  // ---------------- device model ----------------
  logic [7:0] got[$];
  logic [7:0] rdq[$];
  logic [7:0] dev_sh = '0;
  int dev_nbit = 0;
  int fcnt = 0;
  bit in_frame = 0;

  assign spi_miso = pat_bit(fcnt);

  always @(negedge spi_sclk or negedge spi_cs_n or posedge spi_cs_n) begin
    if (spi_cs_n) in_frame = 0;
    else if (!in_frame) begin
      in_frame = 1;
      fcnt = 0;
    end else fcnt++;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      dev_sh = {dev_sh[6:0], spi_mosi};
      dev_nbit++;
      if (dev_nbit == 8) begin
        got.push_back(dev_sh);
        dev_nbit = 0;
      end
    end
  end

  // ---------------- per-clock reference checks ----------------
  int frames = 0;
  int hi_len = 100;
  int setup_len = 0;
  int sh_len = 0;
  bit wait_rise = 0;
  logic prev_cs = 1'b1;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) rdq.push_back(rd_data);
      if (spi_cs_n) check(!spi_sclk, "R6", "sclk low while cs high", spi_sclk, 0);
      if (!spi_cs_n) check(busy, "R7", "busy during frame", busy, 1);
      if (wr_ready && !wr_valid) check(!spi_sclk, "R8", "sclk parked in stall", spi_sclk, 0);
      if (spi_cs_n && !prev_cs) frames++;
      if (spi_cs_n) hi_len++;
      if (!spi_cs_n && prev_cs) begin
        check(hi_len >= GAP, "R6", "cs high gap", hi_len, GAP);
        hi_len = 0;
        setup_len = 0;
        wait_rise = 1;
      end
      if (!spi_cs_n && wait_rise && !spi_sclk) setup_len++;
      if (spi_sclk && !prev_sclk) begin
        if (wait_rise) check(setup_len == HALF, "R6", "cs to first rise", setup_len, HALF);
        wait_rise = 0;
        sh_len = 0;
      end
      if (spi_sclk) sh_len++;
      if (!spi_sclk && prev_sclk) check(sh_len == HALF, "R5", "sclk high phase", sh_len, HALF);
      prev_cs = spi_cs_n;
      prev_sclk = spi_sclk;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic issue(input logic [1:0] op, input logic [21:0] addr,
                       input int len, input logic [7:0] cmd,
                       output bit err_seen, output bit busy_seen);
    @(negedge clk);
    req_op = op; req_addr = addr; req_len = LEN_W'(len); req_cmd = cmd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    err_seen = req_err;
    busy_seen = busy;
  endtask

  task automatic feed(input int n, input int base, input int stall);
    for (int i = 0; i < n; i++) begin
      while (!wr_ready) @(negedge clk);
      repeat (stall) @(negedge clk);
      wr_data = pat(base + i);
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic cmp_bytes(input string req, input int pos, input logic [7:0] exp);
    if (pos < got.size())
      check(got[pos] == exp, req, $sformatf("frame byte %0d", pos), got[pos], exp);
    else
      check(0, req, $sformatf("frame byte %0d missing", pos), -1, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    bit e, b;
    int f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(spi_cs_n == 1'b1, "R10", "cs_n after reset", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R10", "sclk after reset", spi_sclk, 0);
    check({busy, req_err, rd_valid, wr_ready, irq_pulse} == 5'b0, "R10",
          "status after reset", {busy, req_err, rd_valid, wr_ready, irq_pulse}, 0);

    // R9 interrupt edge
    irq_in = 1'b1;
    @(negedge clk); check(!irq_pulse, "R9", "no pulse after 1 edge", irq_pulse, 0);
    @(negedge clk); check(!irq_pulse, "R9", "no pulse after 2 edges", irq_pulse, 0);
    @(negedge clk); check(irq_pulse, "R9", "pulse after 3 edges", irq_pulse, 1);
    @(negedge clk); check(!irq_pulse, "R9", "pulse one cycle", irq_pulse, 0);
    f0 = 0;
    repeat (6) begin @(negedge clk); if (irq_pulse) f0++; end
    irq_in = 1'b0;
    repeat (6) begin @(negedge clk); if (irq_pulse) f0++; end
    check(f0 == 0, "R9", "no pulse on hold or fall", f0, 0);

    // R1 write, no stall
    got.delete();
    issue(2'b01, 22'h2A5C3E, 5, 8'h00, e, b);
    check(b && !e, "R7", "busy after write accept", b, 1);
    feed(5, 100, 0);
    wait_idle();
    check(got.size() == 8, "R1", "write frame length", got.size(), 8);
    cmp_bytes("R1", 0, 8'hAA);
    cmp_bytes("R1", 1, 8'h5C);
    cmp_bytes("R1", 2, 8'h3E);
    for (int i = 0; i < 5; i++) cmp_bytes("R1", 3 + i, pat(100 + i));

    // R8 write with stalls
    got.delete();
    issue(2'b01, 22'h3FFFFF, 3, 8'h00, e, b);
    feed(3, 50, 7);
    wait_idle();
    check(got.size() == 6, "R8", "stalled write length", got.size(), 6);
    cmp_bytes("R8", 0, 8'hBF);
    for (int i = 0; i < 3; i++) cmp_bytes("R8", 3 + i, pat(50 + i));

    // R2 read
    got.delete(); rdq.delete();
    issue(2'b00, 22'h012345, 6, 8'h00, e, b);
    wait_idle();
    check(got.size() == 10, "R2", "read frame length", got.size(), 10);
    cmp_bytes("R2", 0, 8'h01);
    cmp_bytes("R2", 1, 8'h23);
    cmp_bytes("R2", 2, 8'h45);
    for (int i = 3; i < 10; i++) cmp_bytes("R2", i, 8'h00);
    check(rdq.size() == 6, "R2", "read byte count", rdq.size(), 6);
    for (int i = 0; i < 6 && i < rdq.size(); i++)
      check(rdq[i] == pat(4 + i), "R2", $sformatf("read byte %0d", i), rdq[i], pat(4 + i));

    // R3 commands
    foreach (got[i]) got.delete();
    got.delete();
    issue(2'b10, 22'h155555, 9, 8'h00, e, b);
    wait_idle();
    check(got.size() == 3, "R3", "cmd 0x00 length", got.size(), 3);
    cmp_bytes("R3", 0, 8'h00); cmp_bytes("R3", 1, 8'h00); cmp_bytes("R3", 2, 8'h00);
    got.delete();
    issue(2'b10, 22'h3FFFFF, 200, 8'h44, e, b);
    wait_idle();
    check(got.size() == 3, "R3", "cmd 0x44 length", got.size(), 3);
    cmp_bytes("R3", 0, 8'h44); cmp_bytes("R3", 1, 8'h00); cmp_bytes("R3", 2, 8'h00);

    // R4 limits
    f0 = frames;
    issue(2'b01, 22'h000010, WR_MAX + 1, 8'h00, e, b);
    check(e && !b, "R4", "write over limit refused", {e, b}, 2);
    issue(2'b00, 22'h000010, RD_MAX + 1, 8'h00, e, b);
    check(e && !b, "R4", "read over limit refused", {e, b}, 2);
    issue(2'b11, 22'h000010, 1, 8'h00, e, b);
    check(e && !b, "R4", "invalid op refused", {e, b}, 2);
    @(negedge clk);
    check(!req_err, "R4", "error is one cycle", req_err, 0);
    repeat (10) @(negedge clk);
    check(frames == f0, "R4", "no frame on refusal", frames - f0, 0);
    got.delete();
    issue(2'b01, 22'h000010, WR_MAX, 8'h00, e, b);
    check(b && !e, "R4", "write at limit accepted", {e, b}, 1);
    feed(WR_MAX, 0, 0);
    wait_idle();
    check(got.size() == WR_MAX + 3, "R4", "limit write length", got.size(), WR_MAX + 3);
    got.delete(); rdq.delete();
    issue(2'b00, 22'h000010, RD_MAX, 8'h00, e, b);
    check(b && !e, "R4", "read at limit accepted", {e, b}, 1);
    wait_idle();
    check(rdq.size() == RD_MAX, "R4", "limit read count", rdq.size(), RD_MAX);

    // R7 request while busy is ignored
    got.delete(); rdq.delete();
    f0 = frames;
    issue(2'b01, 22'h00ABCD, 2, 8'h00, e, b);
    issue(2'b00, 22'h111111, 4, 8'h00, e, b);
    check(!e, "R7", "no error while busy", e, 0);
    feed(2, 7, 0);
    wait_idle();
    repeat (20) @(negedge clk);
    check(frames - f0 == 1, "R7", "one frame only", frames - f0, 1);
    check(got.size() == 5, "R7", "frame from first request", got.size(), 5);
    check(rdq.size() == 0, "R7", "no read data", rdq.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule